// File: doc/BRIEF.md
# Express Channel Credit Manager

This block tracks how many downstream buffers a router's express sender may still fill, for every express channel length class. A class covers one hop length, from 2 hops up to a configured maximum, so there are one fewer classes than that maximum. Each class owns one reserved buffer that no other class can use. This slot guarantees that every class can always make progress. Beyond that slot, a class borrows from a shared pool, up to a quota. Short-hop classes get larger quotas than long-hop classes.

A sender asks to transmit one flit on one class. The request is accepted in the same cycle only when a buffer for that class is known to be free downstream. Credits come back as single-cycle pulses that carry the class and the number of hops the credit travelled. A credit whose hop count does not match its class is discarded. The block presents a permission bit for every class, the count left in the shared pool, and a free count for every class.

Top module: `ehc_credit_mgr`

## Requirements
- R1: After reset the pool holds SHARED credits, every reserved slot is full, every class is granted, and the free count of class k is 1 + min(quota(k), SHARED).
- R2: Class index k stands for hop length k+2. Its quota is max(1, QMAX >> k), so quotas never grow as hop length increases.
- R3: A send request on class k is accepted (`snd_ok` high, in the same cycle) exactly when `grant_vec[k]` is high. `grant_vec[k]` is high when the reserved slot of k is free, or when the pool is non-empty and class k holds fewer shared credits than its quota.
- R4: An accepted send takes a shared credit whenever it is allowed to. It uses the reserved slot only when no shared credit can be taken.
- R5: A valid credit return first refills the class's reserved slot. If that slot is already full, the return gives one held shared credit back to the pool.
- R6: A credit return whose hop field differs from its class index + 2, or whose class index is out of range, changes no count.
- R7: A return to a class whose reserved slot is full and which holds no shared credit is dropped. The pool never exceeds SHARED.
- R8: When a send and a return arrive in the same cycle, the send is decided on the state before the edge. The return is then applied to the state the send left, so no credit is lost or duplicated.
- R9: A class never holds more shared credits than its quota. Each free count equals the reserved bit plus min(quota - held, pool), so it can neither underflow nor exceed 1 + quota.
- R10: A class whose reserved slot is free is granted even when the pool is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_vld | input | 1 | Send request for one flit |
| snd_cls | input | CLSW | Class index of the send request |
| snd_ok | output | 1 | Send accepted this cycle |
| grant_vec | output | NCLS | Permission to send, one bit per class |
| ret_vld | input | 1 | Credit return pulse |
| ret_cls | input | CLSW | Class index of the returned credit |
| ret_hops | input | HOPW | Hops the returned credit travelled |
| pool_free | output | PW | Credits left in the shared pool |
| cls_free | output | NCLS*CW | Free count per class, class k in bits [k*CW +: CW] |

## Verification
The bench uses the default build: LMAX = 5, SHARED = 8 and QMAX = 6. This gives four classes with quotas 6, 3, 1 and 1, which is small enough that directed sequences can empty the whole pool and then every reserved slot. It then checks the boundary cases: a fully starved state, a reserved-only grant, dropped surplus returns, mismatched hop fields, and a send and a return on the same class in one cycle. A long seeded random run with mostly valid returns then compares every output against a reference model after each cycle.

// File: rtl/ehc_pkg.sv
package ehc_pkg;

    // where an accepted send draws its credit from
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_SHARED = 2'd1,
        SRC_RESV   = 2'd2
    } alloc_src_e;

    // what a valid credit return does to a class
    typedef enum logic [1:0] {
        RET_DROP = 2'd0,
        RET_RESV = 2'd1,
        RET_POOL = 2'd2
    } ret_act_e;

    // shared-credit quota of class index k (hop length k+2)
    function automatic int quota_of(input int k, input int qmax);
        int q;
        q = qmax >> k;
        if (q < 1) q = 1;
        return q;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ehc_ret_filter.sv
module ehc_ret_filter #(
    parameter int NCLS = 4,
    parameter int CLSW = 2,
    parameter int HOPW = 3
) (
    input  logic            ret_vld,
    input  logic [CLSW-1:0] ret_cls,
    input  logic [HOPW-1:0] ret_hops,
    output logic [NCLS-1:0] ret_hit
);
    always_comb begin
        ret_hit = '0;
        for (int k = 0; k < NCLS; k++) begin
            if (ret_vld && (int'(ret_cls) == k) && (int'(ret_hops) == k + 2))
                ret_hit[k] = 1'b1;
        end
    end
endmodule

// File: rtl/ehc_send_steer.sv
module ehc_send_steer #(
    parameter int NCLS = 4,
    parameter int CLSW = 2
) (
    input  logic            snd_vld,
    input  logic [CLSW-1:0] snd_cls,
    input  logic [NCLS-1:0] grant,
    output logic [NCLS-1:0] take,
    output logic            snd_ok
);
    always_comb begin
        take = '0;
        for (int k = 0; k < NCLS; k++) begin
            if (snd_vld && (int'(snd_cls) == k) && grant[k])
                take[k] = 1'b1;
        end
        snd_ok = |take;
    end
endmodule

// File: rtl/ehc_pool.sv
module ehc_pool #(
    parameter int SHARED = 8,
    parameter int NCLS   = 4,
    parameter int PW     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCLS-1:0] take_vec,
    input  logic [NCLS-1:0] rel_vec,
    output logic [PW-1:0]   pool_cnt
);
    logic take_any;
    logic rel_any;
    logic [PW-1:0] cnt_n;

    always_comb begin
        take_any = |take_vec;
        rel_any  = |rel_vec;
        cnt_n    = pool_cnt;
        if (take_any) cnt_n = cnt_n - PW'(1);
        if (rel_any)  cnt_n = cnt_n + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) pool_cnt <= PW'(SHARED);
        else     pool_cnt <= cnt_n;
    end

    AST_POOL_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(pool_cnt) <= SHARED); // R7
    AST_POOL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!take_any && !rel_any) |=> $stable(pool_cnt)); // R5
    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take_vec)); // R3
endmodule

// File: rtl/ehc_class_slot.sv
module ehc_class_slot
    import ehc_pkg::*;
#(
    parameter int QUOTA = 1,
    parameter int HW    = 3,
    parameter int PW    = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pool_cnt,
    input  logic          take,
    input  logic          ret,
    output logic          grant,
    output logic          pool_take,
    output logic          pool_rel,
    output logic [CW-1:0] free_cnt
);
    localparam int MW = max_int(HW, PW);

    logic          resv;
    logic [HW-1:0] held;
    logic          pool_nz;
    logic          shared_ok;
    alloc_src_e    src;
    ret_act_e      act;
    logic          resv_a, resv_n;
    logic [HW-1:0] held_a, held_n;
    logic [MW-1:0] room_x, pool_x, avail_x;

    always_comb begin
        pool_nz   = (pool_cnt != '0);
        shared_ok = pool_nz && (int'(held) < QUOTA);
        grant     = resv || shared_ok;

        // send: shared first, reserved last
        src = SRC_NONE;
        if (take) begin
            if (shared_ok)  src = SRC_SHARED;
            else if (resv)  src = SRC_RESV;
        end
        held_a = (src == SRC_SHARED) ? held + HW'(1) : held;
        resv_a = (src == SRC_RESV) ? 1'b0 : resv;

        // return applied on top of the send result
        act = RET_DROP;
        if (ret) begin
            if (!resv_a)            act = RET_RESV;
            else if (held_a != '0)  act = RET_POOL;
        end
        held_n = (act == RET_POOL) ? held_a - HW'(1) : held_a;
        resv_n = (act == RET_RESV) ? 1'b1 : resv_a;

        pool_take = (src == SRC_SHARED);
        pool_rel  = (act == RET_POOL);

        room_x  = MW'(HW'(QUOTA) - held);
        pool_x  = MW'(pool_cnt);
        avail_x = (pool_x < room_x) ? pool_x : room_x;
        free_cnt = CW'(resv) + CW'(avail_x);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resv <= 1'b1;
            held <= '0;
        end else begin
            resv <= resv_n;
            held <= held_n;
        end
    end

    AST_HELD_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(held) <= QUOTA); // R9
    AST_RET_REFILL: assert property (@(posedge clk) disable iff (rst)
        (ret && !take && !resv) |=> resv); // R5
    AST_SHARED_FIRST: assert property (@(posedge clk) disable iff (rst)
        (take && !ret && pool_nz && int'(held) < QUOTA) |=> (resv == $past(resv))); // R4
    AST_RESV_GRANT: assert property (@(posedge clk) disable iff (rst)
        (take && resv && !pool_nz && !ret) |=> !resv); // R10
endmodule

// File: rtl/ehc_credit_mgr.sv
module ehc_credit_mgr
    import ehc_pkg::*;
#(
    parameter int LMAX   = 5,
    parameter int SHARED = 8,
    parameter int QMAX   = 6,
    localparam int NCLS  = LMAX - 1,
    localparam int CLSW  = (NCLS > 1) ? $clog2(NCLS) : 1,
    localparam int HOPW  = $clog2(LMAX + 1),
    localparam int PW    = $clog2(SHARED + 1),
    localparam int HW    = $clog2(QMAX + 1),
    localparam int CW    = $clog2(QMAX + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               snd_vld,
    input  logic [CLSW-1:0]    snd_cls,
    output logic               snd_ok,
    output logic [NCLS-1:0]    grant_vec,
    input  logic               ret_vld,
    input  logic [CLSW-1:0]    ret_cls,
    input  logic [HOPW-1:0]    ret_hops,
    output logic [PW-1:0]      pool_free,
    output logic [NCLS*CW-1:0] cls_free
);
    logic [NCLS-1:0] take_vec;
    logic [NCLS-1:0] hit_vec;
    logic [NCLS-1:0] ptake_vec;
    logic [NCLS-1:0] prel_vec;

    ehc_send_steer #(.NCLS(NCLS), .CLSW(CLSW)) steer_i (
        .snd_vld (snd_vld),
        .snd_cls (snd_cls),
        .grant   (grant_vec),
        .take    (take_vec),
        .snd_ok  (snd_ok)
    );

    ehc_ret_filter #(.NCLS(NCLS), .CLSW(CLSW), .HOPW(HOPW)) filt_i (
        .ret_vld  (ret_vld),
        .ret_cls  (ret_cls),
        .ret_hops (ret_hops),
        .ret_hit  (hit_vec)
    );

    ehc_pool #(.SHARED(SHARED), .NCLS(NCLS), .PW(PW)) pool_i (
        .clk      (clk),
        .rst      (rst),
        .take_vec (ptake_vec),
        .rel_vec  (prel_vec),
        .pool_cnt (pool_free)
    );

    for (genvar k = 0; k < NCLS; k++) begin : g_cls
        ehc_class_slot #(
            .QUOTA (quota_of(k, QMAX)),
            .HW    (HW),
            .PW    (PW),
            .CW    (CW)
        ) slot_i (
            .clk       (clk),
            .rst       (rst),
            .pool_cnt  (pool_free),
            .take      (take_vec[k]),
            .ret       (hit_vec[k]),
            .grant     (grant_vec[k]),
            .pool_take (ptake_vec[k]),
            .pool_rel  (prel_vec[k]),
            .free_cnt  (cls_free[k*CW +: CW])
        );
    end

    AST_BAD_RET_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ret_vld && (hit_vec == '0) && !snd_ok) |=> ($stable(pool_free) && $stable(cls_free))); // R6
    AST_SEND_COSTS: assert property (@(posedge clk) disable iff (rst)
        (snd_ok && !ret_vld) |=> (cls_free != $past(cls_free))); // R3
endmodule

// File: tb/ehc_credit_mgr_tb_top.sv
module ehc_credit_mgr_tb_top;
    localparam int PERIOD = 10;
    localparam int LMAX   = 5;
    localparam int SHARED = 8;
    localparam int QMAX   = 6;
    localparam int NCLS   = LMAX - 1;
    localparam int CLSW   = 2;
    localparam int HOPW   = 3;
    localparam int PW     = 4;
    localparam int CW     = 3;

    logic clk = 1'b0;
    logic rst;
    logic snd_vld;
    logic [CLSW-1:0] snd_cls;
    logic snd_ok;
    logic [NCLS-1:0] grant_vec;
    logic ret_vld;
    logic [CLSW-1:0] ret_cls;
    logic [HOPW-1:0] ret_hops;
    logic [PW-1:0] pool_free;
    logic [NCLS*CW-1:0] cls_free;

    always #(PERIOD/2) clk = ~clk;

    ehc_credit_mgr #(.LMAX(LMAX), .SHARED(SHARED), .QMAX(QMAX)) dut_i (
        .clk(clk), .rst(rst),
        .snd_vld(snd_vld), .snd_cls(snd_cls), .snd_ok(snd_ok), .grant_vec(grant_vec),
        .ret_vld(ret_vld), .ret_cls(ret_cls), .ret_hops(ret_hops),
        .pool_free(pool_free), .cls_free(cls_free)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    int m_pool;
    int m_held [NCLS];
    int m_resv [NCLS];

    function automatic int quota(input int k);
        int q = QMAX >> k;
        return (q < 1) ? 1 : q;
    endfunction

    function automatic int m_grant(input int k);
        return (m_resv[k] == 1 || (m_pool > 0 && m_held[k] < quota(k))) ? 1 : 0;
    endfunction

    function automatic int m_free(input int k);
        int room = quota(k) - m_held[k];
        return m_resv[k] + ((m_pool < room) ? m_pool : room);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic m_reset();
        m_pool = SHARED;
        for (int k = 0; k < NCLS; k++) begin
            m_held[k] = 0;
            m_resv[k] = 1;
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "pool_free", int'(pool_free), m_pool);
        for (int k = 0; k < NCLS; k++) begin
            chk(req, $sformatf("cls_free[%0d]", k), int'(cls_free[k*CW +: CW]), m_free(k));
            chk(req, $sformatf("grant[%0d]", k), int'(grant_vec[k]), m_grant(k));
        end
    endtask

    // one cycle, called at a falling edge; returns acceptance
    task automatic step(input bit sv, input int sc, input bit rv, input int rc,
                        input int rh, input string req, output bit ok);
        int exp_ok;
        snd_vld  = sv;
        snd_cls  = CLSW'(sc);
        ret_vld  = rv;
        ret_cls  = CLSW'(rc);
        ret_hops = HOPW'(rh);
        #1;
        exp_ok = (sv && m_grant(sc) == 1) ? 1 : 0;
        chk(req, "snd_ok", int'(snd_ok), exp_ok);
        ok = snd_ok;
        @(posedge clk);
        // model: send on old state, then return
        if (exp_ok == 1) begin
            if (m_pool > 0 && m_held[sc] < quota(sc)) begin
                m_held[sc]++;
                m_pool--;
            end else begin
                m_resv[sc] = 0;
            end
        end
        if (rv && rc < NCLS && rh == rc + 2) begin
            if (m_resv[rc] == 0) m_resv[rc] = 1;
            else if (m_held[rc] > 0) begin
                m_held[rc]--;
                m_pool++;
            end
        end
        @(negedge clk);
        snd_vld = 1'b0;
        ret_vld = 1'b0;
        check_state(req);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit ok;
        int acc;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        snd_vld = 0; snd_cls = 0; ret_vld = 0; ret_cls = 0; ret_hops = 0;
        m_reset();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, literal values
        chk("R1", "pool after reset", int'(pool_free), 8);
        chk("R1", "grants after reset", int'(grant_vec), 4'hf);
        chk("R1", "class0 free", int'(cls_free[0 +: CW]), 7);
        chk("R1", "class1 free", int'(cls_free[CW +: CW]), 4);
        chk("R1", "class3 free", int'(cls_free[3*CW +: CW]), 2);

        // R2 / R4: class0 quota 6 shared then reserved = 7 accepts
        acc = 0;
        for (int i = 0; i < 8; i++) begin
            step(1, 0, 0, 0, 0, "R4", ok);
            acc += ok;
        end
        chk("R2", "class0 accepted sends", acc, 7);
        chk("R4", "pool after class0 drain", int'(pool_free), 2);

        // R10: empty the pool, reserved slots still granted
        acc = 0;
        for (int i = 0; i < 4; i++) begin
            step(1, 1, 0, 0, 0, "R3", ok);
            acc += ok;
        end
        chk("R2", "class1 accepted sends", acc, 3);
        chk("R10", "pool empty", int'(pool_free), 0);
        chk("R10", "class2 granted by reserved slot", int'(grant_vec[2]), 1);
        step(1, 2, 0, 0, 0, "R10", ok);
        chk("R10", "class2 send accepted", int'(ok), 1);
        step(1, 3, 0, 0, 0, "R10", ok);
        step(1, 2, 0, 0, 0, "R10", ok);
        chk("R10", "class2 second send refused", int'(ok), 0);
        chk("R10", "all grants low", int'(grant_vec), 0);

        // R6: mismatched hop field ignored
        step(0, 0, 1, 1, 4, "R6", ok);
        chk("R6", "class1 free after bad hop", int'(cls_free[CW +: CW]), 0);
        chk("R6", "pool after bad hop", int'(pool_free), 0);

        // R5: reserved slot first, then pool
        step(0, 0, 1, 1, 3, "R5", ok);
        chk("R5", "class1 free after refill", int'(cls_free[CW +: CW]), 1);
        chk("R5", "pool unchanged by refill", int'(pool_free), 0);
        step(0, 0, 1, 1, 3, "R5", ok);
        chk("R5", "pool after second return", int'(pool_free), 1);

        // R8: send and return on class3 in one cycle
        step(1, 3, 1, 3, 5, "R8", ok);
        chk("R8", "same-cycle send accepted", int'(ok), 1);
        chk("R8", "pool after same-cycle", int'(pool_free), 0);
        chk("R8", "class3 free after same-cycle", int'(cls_free[3*CW +: CW]), 1);

        // R7: surplus return dropped
        step(0, 0, 1, 2, 4, "R7", ok);
        step(0, 0, 1, 2, 4, "R7", ok);
        chk("R7", "pool after surplus return", int'(pool_free), 0);
        chk("R7", "class2 free after surplus return", int'(cls_free[2*CW +: CW]), 1);

        // random phase against the model: R3 R8 R9
        for (int i = 0; i < 3000; i++) begin
            bit sv, rv;
            int sc, rc, rh;
            sv = ($urandom % 2) == 0;
            rv = ($urandom % 2) == 0;
            sc = $urandom % NCLS;
            rc = $urandom % NCLS;
            rh = (($urandom % 6) == 0) ? int'($urandom % 8) : rc + 2;
            step(sv, sc, rv, rc, rh, "R9", ok);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule